// File: doc/BRIEF.md
# Low-Power Sleep State Controller

This block decides which low-power state a processor core enters when a sleep instruction retires. It brings the core back to running when an interrupt becomes pending. Two configuration bits, each taken from bit 7 of a standby-control register, choose the depth of sleep. The bit from the first register is tested first.

The state chosen sets which peripheral groups receive a halt enable:

- **Plain sleep** only stalls the instruction pipeline.
- **Deep sleep** also halts the DMA engine.
- **Standby** halts the timer, the serial port, the performance counters and the DMA. It first spends one cycle pulsing a synchronise request, so that those peripherals can bring their state up to date before the halt takes effect.

A wake-up from any low-power state raises a one-cycle pulse. The interrupt-entry logic uses this pulse to take the request.

Top module: `lowpower_state_ctl`

## Requirements
- R1: After reset, `pstate` is 0 (running) and every other output is 0. `pstate` encodes running = 0, plain sleep = 1, deep sleep = 2 and standby = 3.
- R2: When `sleep_req` is 1 in running state and `stby_bit` is 1, `pstate` becomes 3 at the next clock edge, whatever the value of `deep_bit`.
- R3: When `sleep_req` is 1 in running state, `stby_bit` is 0 and `deep_bit` is 1, `pstate` becomes 2 at the next clock edge.
- R4: When `sleep_req` is 1 in running state and both select bits are 0, `pstate` becomes 1 at the next clock edge. In plain sleep, none of the four halt outputs is raised.
- R5: In the first cycle of standby, `periph_sync` is 1 and all halt outputs are 0. From the second cycle of standby, `halt_timer`, `halt_serial`, `halt_perf` and `halt_dma` are 1 and `periph_sync` is 0.
- R6: In deep sleep, `halt_dma` is 1 and `halt_timer`, `halt_serial` and `halt_perf` are 0.
- R7: When `irq_pending` is 1 in any non-running state, `pstate` becomes 0 at the next edge. `wake_pulse` is 1 for exactly that one cycle.
- R8: `irq_pending` in running state has no effect: `pstate` stays 0 and `wake_pulse` stays 0.
- R9: `sleep_req` in a non-running state is ignored: the state and its halt outputs do not change.
- R10: `cpu_stall` is 1 in every non-running state and 0 in running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe: a sleep instruction retired |
| stby_bit | input | 1 | Bit 7 of the first standby-control register; selects standby |
| deep_bit | input | 1 | Bit 7 of the second standby-control register; selects deep sleep |
| irq_pending | input | 1 | An interrupt request is pending |
| pstate | output | 2 | Current power state (0 run, 1 sleep, 2 deep sleep, 3 standby) |
| cpu_stall | output | 1 | Instruction pipeline stalled |
| periph_sync | output | 1 | Request to bring timer, serial and performance counters up to date |
| halt_timer | output | 1 | Halt enable for the timer group |
| halt_serial | output | 1 | Halt enable for the serial port group |
| halt_perf | output | 1 | Halt enable for the performance-counter group |
| halt_dma | output | 1 | Halt enable for the DMA group |
| wake_pulse | output | 1 | One-cycle pulse on an interrupt wake-up |

## Verification
A corrupted state register shows at once on `pstate` and `cpu_stall`. It also shows in the same cycle as a wrong set of halt enables, because those enables decode directly from the state. A stuck or missing standby settle flag shows one cycle after entry: either `periph_sync` persists, or the halts never rise. Every combination of select bits is swept against every dwell time of zero to two cycles before an interrupt. This catches a wrong selection order and a missing or doubled wake pulse within one cycle of the event.

// File: rtl/lowpower_state_ctl.sv
module lowpower_state_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       stby_bit,
  input  logic       deep_bit,
  input  logic       irq_pending,
  output logic [1:0] pstate,
  output logic       cpu_stall,
  output logic       periph_sync,
  output logic       halt_timer,
  output logic       halt_serial,
  output logic       halt_perf,
  output logic       halt_dma,
  output logic       wake_pulse
);

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_NAP  = 2'd1;
  localparam logic [1:0] ST_DEEP = 2'd2;
  localparam logic [1:0] ST_STBY = 2'd3;

  logic [1:0] cur, nxt;
  logic       settled;
  logic       wake_q;

  always_comb begin
    nxt = cur;
    if (cur == ST_RUN) begin
      if (sleep_req) begin
        if (stby_bit)      nxt = ST_STBY;
        else if (deep_bit) nxt = ST_DEEP;
        else               nxt = ST_NAP;
      end
    end else if (irq_pending) begin
      nxt = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= ST_RUN;
      settled <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      cur     <= nxt;
      settled <= (cur == ST_STBY) && (nxt == ST_STBY);
      wake_q  <= (cur != ST_RUN) && irq_pending;
    end
  end

  logic grp_halt;
  assign grp_halt    = (cur == ST_STBY) && settled;
  assign pstate      = cur;
  assign cpu_stall   = (cur != ST_RUN);
  assign periph_sync = (cur == ST_STBY) && !settled;
  assign halt_timer  = grp_halt;
  assign halt_serial = grp_halt;
  assign halt_perf   = grp_halt;
  assign halt_dma    = grp_halt || (cur == ST_DEEP);
  assign wake_pulse  = wake_q;

  // R2
  stby_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == ST_RUN && sleep_req && stby_bit) |=> (pstate == ST_STBY));

  // R3
  deep_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == ST_RUN && sleep_req && !stby_bit && deep_bit) |=> (pstate == ST_DEEP));

  // R5
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_timer) |-> $past(periph_sync));

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != ST_RUN && irq_pending) |=> (pstate == ST_RUN && wake_pulse));

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R8
  run_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == ST_RUN && !sleep_req) |=> (pstate == ST_RUN && !wake_pulse));

  // R9
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != ST_RUN && !irq_pending) |=> $stable(pstate));

endmodule

// File: tb/tb_lowpower_state_ctl.sv
module tb_lowpower_state_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, stby_bit = 1'b0, deep_bit = 1'b0, irq_pending = 1'b0;
  logic [1:0] pstate;
  logic cpu_stall, periph_sync, halt_timer, halt_serial, halt_perf, halt_dma, wake_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lowpower_state_ctl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_bit(stby_bit),
    .deep_bit(deep_bit), .irq_pending(irq_pending), .pstate(pstate),
    .cpu_stall(cpu_stall), .periph_sync(periph_sync), .halt_timer(halt_timer),
    .halt_serial(halt_serial), .halt_perf(halt_perf), .halt_dma(halt_dma),
    .wake_pulse(wake_pulse));

  // {pstate, stall, sync, timer, serial, perf, dma, wake}
  function automatic logic [8:0] observe();
    return {pstate, cpu_stall, periph_sync, halt_timer, halt_serial, halt_perf, halt_dma, wake_pulse};
  endfunction

  function automatic logic [8:0] expect_vec(int st, int n, bit wk);
    logic g, sy, dm;
    g  = (st == 3) && (n >= 1);
    sy = (st == 3) && (n == 0);
    dm = g || (st == 2);
    return {st[1:0], (st != 0), sy, g, g, g, dm, wk};
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 reset", observe(), 9'b0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", observe(), 9'b0);

    // R8: interrupt while running
    irq_pending = 1'b1;
    step();
    chk("R8 irq in run", observe(), expect_vec(0, 0, 0));
    step();
    chk("R8 irq in run held", observe(), expect_vec(0, 0, 0));
    irq_pending = 1'b0;

    for (int sel = 0; sel < 4; sel++) begin
      for (int dwell = 0; dwell < 3; dwell++) begin
        int st;
        st = sel[1] ? 3 : (sel[0] ? 2 : 1);
        stby_bit = sel[1];
        deep_bit = sel[0];
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        // R2 R3 R4 R10 entry, R5 first cycle
        chk(st == 3 ? "R2 R5 standby entry" : (st == 2 ? "R3 R6 deep entry" : "R4 R10 sleep entry"),
            observe(), expect_vec(st, 0, 0));
        for (int n = 1; n <= dwell; n++) begin
          step();
          chk(st == 3 ? "R5 standby settled" : "R6 R10 dwell", observe(), expect_vec(st, n, 0));
        end
        // R9: sleep again while asleep, opposite selection
        stby_bit = ~sel[1];
        deep_bit = ~sel[0];
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R9 sleep ignored", observe(), expect_vec(st, dwell + 1, 0));
        irq_pending = 1'b1;
        step();
        irq_pending = 1'b0;
        chk("R7 wake", observe(), expect_vec(0, 0, 1));
        step();
        chk("R7 wake pulse ends", observe(), expect_vec(0, 0, 0));
      end
    end

    // R1: reset in the middle of standby
    stby_bit = 1'b1;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    step();
    chk("R5 standby before reset", observe(), expect_vec(3, 1, 0));
    rst_n = 1'b0;
    #1;
    chk("R1 reset from standby", observe(), 9'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 run after reset", observe(), 9'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule